// File: doc/BRIEF.md
# CAN Status Interrupt Controller

This block sits beside a CAN protocol engine. It keeps the controller's status byte and raises a status interrupt when selected status events occur. The engine reports levels for bus-off, error warning and error passive. It also reports one-cycle pulses when a frame was received or transmitted correctly, and when it stores a new last-error code. Two enable inputs, taken from a control register, decide which event group may interrupt. One enable covers the error group (bus-off, warning). The other covers the status-change group (receive OK, transmit OK, last-error update).

A pending status interrupt owns the interrupt identifier and shows the code 8000h. When nothing is pending, the identifier passes through the code of a lower-priority source, such as message-object interrupts, so that those codes are left in place. A CPU port can read the status byte or the identifier, and can write the status bits that software may change. Reading the status byte acknowledges the pending status interrupt. The interrupt line is a registered level that is high whenever the identifier is non-zero.

Top module: `can_stat_irq`

## Requirements
- R1: With `en_err` high, a 0-to-1 change of `eng_boff` or `eng_ewarn` sets the identifier to 8000h after the next clock edge. With `en_err` low, or while the flag stays high or falls, no interrupt is raised.
- R2: With `en_chg` high, a pulse on `eng_rx_ok`, `eng_tx_ok` or `eng_lec_upd` sets the identifier to 8000h after the next clock edge. With `en_chg` low, such a pulse raises nothing.
- R3: A change of `eng_epass` in either direction never raises the status interrupt.
- R4: Status byte layout: bits 2:0 hold the last-error code, bit 3 transmit OK and bit 4 receive OK. A CPU write (`cpu_wr`, `cpu_addr`=0) loads these bits from `cpu_wdata` but never raises the interrupt. An engine pulse in the same cycle wins over the write.
- R5: Bits 7, 6 and 5 of the status byte are bus-off, warning and passive. Each follows the engine flag registered one cycle. CPU writes do not change them.
- R6: While the status interrupt is pending, `irq_id` is 8000h. A read with `cpu_addr`=1 returns it on `cpu_rdata` and does not acknowledge it.
- R7: A status read (`cpu_rd`, `cpu_addr`=0) clears a pending status interrupt at that clock edge. `cpu_rdata` then returns the status byte as it was before the edge, zero-extended.
- R8: A qualifying event in the same cycle as a status read leaves the interrupt pending.
- R9: With no status interrupt pending, `irq_id` equals `low_code` registered one cycle, which is 0000h when the lower source is idle.
- R10: `irq` is high exactly when `irq_id` is non-zero.
- R11: Synchronous reset clears the status byte, the pending flag, `irq_id`, `irq` and `cpu_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_boff | input | 1 | Bus-off level from the protocol engine |
| eng_ewarn | input | 1 | Error-warning level from the engine |
| eng_epass | input | 1 | Error-passive level from the engine |
| eng_rx_ok | input | 1 | Pulse: frame received correctly |
| eng_tx_ok | input | 1 | Pulse: frame transmitted correctly |
| eng_lec_upd | input | 1 | Pulse: engine stores a new last-error code |
| eng_lec | input | 3 | Last-error code stored with `eng_lec_upd` |
| en_err | input | 1 | Enable for error-group interrupts |
| en_chg | input | 1 | Enable for status-change interrupts |
| low_code | input | 16 | Identifier code of the lower-priority source |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 1 | 0 selects the status byte, 1 the identifier |
| cpu_wdata | input | 8 | CPU write data for the status byte |
| cpu_rdata | output | 16 | Registered read data |
| irq_id | output | 16 | Interrupt identifier |
| irq | output | 1 | Interrupt request level |

## Verification
The main function is driven through a sequence that separates the two enables. Each group's rising events are tried with its own enable on and off, and a flag that is already high is held to show that only a rise counts. The passive flag is toggled in both directions to show that it never interrupts. CPU writes are made with both enables on, so a write that wrongly raised the interrupt would be seen. Status reads are placed alone, together with a fresh event, and with different lower-priority codes, which tells an acknowledge apart from a hold and from the pass-through.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int LEC_W   = 3;
  localparam int LEC_LSB = 0;
  localparam int TX_BIT  = 3;
  localparam int RX_BIT  = 4;
  localparam int EP_BIT  = 5;
  localparam int EW_BIT  = 6;
  localparam int BO_BIT  = 7;
  // bits software may write
  localparam logic [STAT_W-1:0] WR_MASK = 8'h1F;
endpackage

// File: rtl/can_stat_reg.sv
module can_stat_reg
  import can_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_boff,
  input  logic              eng_ewarn,
  input  logic              eng_epass,
  input  logic              eng_rx_ok,
  input  logic              eng_tx_ok,
  input  logic              eng_lec_upd,
  input  logic [LEC_W-1:0]  eng_lec,
  input  logic              wr_stat,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] stat_q,
  output logic              rise_err,
  output logic              rise_chg
);
  logic [STAT_W-1:0] wr_val;

  assign wr_val = wdata & WR_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q[BO_BIT] <= eng_boff;
      stat_q[EW_BIT] <= eng_ewarn;
      stat_q[EP_BIT] <= eng_epass;
      if (eng_rx_ok)    stat_q[RX_BIT] <= 1'b1;
      else if (wr_stat) stat_q[RX_BIT] <= wr_val[RX_BIT];
      if (eng_tx_ok)    stat_q[TX_BIT] <= 1'b1;
      else if (wr_stat) stat_q[TX_BIT] <= wr_val[TX_BIT];
      if (eng_lec_upd)  stat_q[LEC_LSB +: LEC_W] <= eng_lec;
      else if (wr_stat) stat_q[LEC_LSB +: LEC_W] <= wr_val[LEC_LSB +: LEC_W];
    end
  end

  // stored flags hold last cycle's level, so a set input over a clear bit is a rise
  assign rise_err = (eng_boff & ~stat_q[BO_BIT]) | (eng_ewarn & ~stat_q[EW_BIT]);
  assign rise_chg = eng_rx_ok | eng_tx_ok | eng_lec_upd;
endmodule

// File: rtl/can_stat_pend.sv
module can_stat_pend (
  input  logic clk,
  input  logic rst,
  input  logic en_err,
  input  logic en_chg,
  input  logic rise_err,
  input  logic rise_chg,
  input  logic stat_rd,
  output logic pend_d,
  output logic pend_q
);
  logic fire;

  assign fire   = (en_err & rise_err) | (en_chg & rise_chg);
  // a fresh event beats the acknowledge in the same cycle
  assign pend_d = fire | (pend_q & ~stat_rd);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/can_stat_idmux.sv
module can_stat_idmux #(
  parameter int          ID_W      = 16,
  parameter int          ST_W      = 8,
  parameter logic [15:0] PEND_CODE = 16'h8000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pend_d,
  input  logic [ID_W-1:0] low_code,
  input  logic            rd,
  input  logic            addr,
  input  logic [ST_W-1:0] stat_q,
  output logic [ID_W-1:0] irq_id,
  output logic            irq,
  output logic [ID_W-1:0] rdata
);
  localparam int PAD_W = ID_W - ST_W;

  logic [ID_W-1:0] id_d;

  assign id_d = pend_d ? ID_W'(PEND_CODE) : low_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_id <= '0;
      irq    <= 1'b0;
      rdata  <= '0;
    end else begin
      irq_id <= id_d;
      irq    <= |id_d;
      if (rd) rdata <= addr ? irq_id : {{PAD_W{1'b0}}, stat_q};
    end
  end
endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
  import can_stat_pkg::*;
#(
  parameter int          ID_W      = 16,
  parameter logic [15:0] PEND_CODE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_boff,
  input  logic              eng_ewarn,
  input  logic              eng_epass,
  input  logic              eng_rx_ok,
  input  logic              eng_tx_ok,
  input  logic              eng_lec_upd,
  input  logic [LEC_W-1:0]  eng_lec,
  input  logic              en_err,
  input  logic              en_chg,
  input  logic [ID_W-1:0]   low_code,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_addr,
  input  logic [STAT_W-1:0] cpu_wdata,
  output logic [ID_W-1:0]   cpu_rdata,
  output logic [ID_W-1:0]   irq_id,
  output logic              irq
);
  logic [STAT_W-1:0] stat_q;
  logic              rise_err;
  logic              rise_chg;
  logic              pend_d;
  logic              pend_q;
  logic              stat_rd;
  logic              stat_wr;

  assign stat_rd = cpu_rd & ~cpu_addr;
  assign stat_wr = cpu_wr & ~cpu_addr;

  can_stat_reg u_reg (
    .clk        (clk),
    .rst        (rst),
    .eng_boff   (eng_boff),
    .eng_ewarn  (eng_ewarn),
    .eng_epass  (eng_epass),
    .eng_rx_ok  (eng_rx_ok),
    .eng_tx_ok  (eng_tx_ok),
    .eng_lec_upd(eng_lec_upd),
    .eng_lec    (eng_lec),
    .wr_stat    (stat_wr),
    .wdata      (cpu_wdata),
    .stat_q     (stat_q),
    .rise_err   (rise_err),
    .rise_chg   (rise_chg)
  );

  can_stat_pend u_pend (
    .clk     (clk),
    .rst     (rst),
    .en_err  (en_err),
    .en_chg  (en_chg),
    .rise_err(rise_err),
    .rise_chg(rise_chg),
    .stat_rd (stat_rd),
    .pend_d  (pend_d),
    .pend_q  (pend_q)
  );

  can_stat_idmux #(
    .ID_W     (ID_W),
    .ST_W     (STAT_W),
    .PEND_CODE(PEND_CODE)
  ) u_idmux (
    .clk     (clk),
    .rst     (rst),
    .pend_d  (pend_d),
    .low_code(low_code),
    .rd      (cpu_rd),
    .addr    (cpu_addr),
    .stat_q  (stat_q),
    .irq_id  (irq_id),
    .irq     (irq),
    .rdata   (cpu_rdata)
  );
endmodule

// File: rtl/can_stat_irq_chk.sv
module can_stat_irq_chk #(
  parameter int          ID_W      = 16,
  parameter logic [15:0] PEND_CODE = 16'h8000
) (
  input logic            clk,
  input logic            rst,
  input logic            eng_boff,
  input logic            eng_ewarn,
  input logic            eng_epass,
  input logic            eng_rx_ok,
  input logic            eng_tx_ok,
  input logic            eng_lec_upd,
  input logic            en_err,
  input logic            en_chg,
  input logic [ID_W-1:0] low_code,
  input logic            cpu_rd,
  input logic            cpu_addr,
  input logic [ID_W-1:0] irq_id,
  input logic            irq,
  input logic [7:0]      stat_q
);
  localparam logic [ID_W-1:0] PC = ID_W'(PEND_CODE);

  logic qual;
  logic low_ok;

  assign qual = (en_err & ((eng_boff & ~stat_q[7]) | (eng_ewarn & ~stat_q[6])))
              | (en_chg & (eng_rx_ok | eng_tx_ok | eng_lec_upd));
  assign low_ok = (low_code != PC);

  assert_boff_rise_R1: assert property (@(posedge clk) disable iff (rst)
    en_err && eng_boff && !stat_q[7] |=> irq_id == PC);

  assert_rx_event_R2: assert property (@(posedge clk) disable iff (rst)
    en_chg && eng_rx_ok |=> irq_id == PC);

  // no qualifying event: passive changes and CPU writes (R4) cannot raise
  assert_no_raise_R3: assert property (@(posedge clk) disable iff (rst)
    !qual && irq_id != PC && low_ok |=> irq_id != PC);

  assert_flags_ro_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stat_q[7:5] == $past({eng_boff, eng_ewarn, eng_epass}));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_rd && !cpu_addr && !qual && low_ok |=> irq_id != PC);

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_rd && !cpu_addr && qual |=> irq_id == PC);

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_id != '0));

  assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq_id == '0 && !irq && stat_q == '0);
endmodule

bind can_stat_irq can_stat_irq_chk #(
  .ID_W     (ID_W),
  .PEND_CODE(PEND_CODE)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .eng_boff   (eng_boff),
  .eng_ewarn  (eng_ewarn),
  .eng_epass  (eng_epass),
  .eng_rx_ok  (eng_rx_ok),
  .eng_tx_ok  (eng_tx_ok),
  .eng_lec_upd(eng_lec_upd),
  .en_err     (en_err),
  .en_chg     (en_chg),
  .low_code   (low_code),
  .cpu_rd     (cpu_rd),
  .cpu_addr   (cpu_addr),
  .irq_id     (irq_id),
  .irq        (irq),
  .stat_q     (stat_q)
);

// File: tb/can_stat_irq_tb_top.sv
module can_stat_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic        ee, es, bo, ew, ep, rx, tx, lw;
    logic [2:0]  lec;
    logic        rd, wr;
    logic [7:0]  wd;
    logic [15:0] low, expv;
    logic [3:0]  req;
  } vec_t;

  // ee es bo ew ep rx tx lw lec rd wr wd low exp req
  localparam vec_t VECS [NV] = '{
    '{0,0,0,0,0,0,0,0,3'd0,0,0,8'h00,16'h0000,16'h0000,4'd9},  // R9 idle
    '{1,0,1,0,0,0,0,0,3'd0,0,0,8'h00,16'h0000,16'h8000,4'd1},  // R1 bus-off rise
    '{1,0,1,0,0,0,0,0,3'd0,1,0,8'h00,16'h0000,16'h0000,4'd7},  // R7 read clears
    '{0,0,1,1,0,0,0,0,3'd0,0,0,8'h00,16'h0000,16'h0000,4'd1},  // R1 warn rise, disabled
    '{1,0,1,1,0,0,0,0,3'd0,0,0,8'h00,16'h0000,16'h0000,4'd1},  // R1 already high
    '{1,1,1,1,1,0,0,0,3'd0,0,0,8'h00,16'h0000,16'h0000,4'd3},  // R3 passive rises
    '{1,1,1,1,0,0,0,0,3'd0,0,0,8'h00,16'h0000,16'h0000,4'd3},  // R3 passive falls
    '{1,1,1,1,0,1,0,0,3'd0,0,0,8'h00,16'h0000,16'h8000,4'd2},  // R2 rx ok
    '{1,1,1,1,0,0,0,0,3'd0,1,0,8'h00,16'h0005,16'h0005,4'd9},  // R9 pass-through
    '{1,1,1,1,0,0,0,0,3'd0,0,1,8'h1F,16'h0005,16'h0005,4'd4},  // R4 write
    '{1,1,1,1,0,0,1,0,3'd0,0,0,8'h00,16'h0005,16'h8000,4'd2},  // R2 tx ok
    '{1,1,1,1,0,0,0,1,3'd3,1,0,8'h00,16'h0005,16'h8000,4'd8},  // R8 read + event
    '{1,1,1,1,0,0,0,0,3'd0,1,0,8'h00,16'h0000,16'h0000,4'd7},  // R7
    '{1,0,1,1,0,1,0,0,3'd0,0,0,8'h00,16'h0000,16'h0000,4'd2},  // R2 disabled
    '{1,1,1,1,0,0,0,1,3'd5,0,0,8'h00,16'h0000,16'h8000,4'd2},  // R2 lec update
    '{1,1,1,1,0,0,0,0,3'd0,1,0,8'h00,16'h0003,16'h0003,4'd9},  // R9
    '{1,1,0,0,0,0,0,0,3'd0,0,0,8'h00,16'h0003,16'h0003,4'd1},  // R1 falls
    '{1,1,0,1,0,0,0,0,3'd0,0,0,8'h00,16'h0003,16'h8000,4'd1}   // R1 warn rise
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eng_boff = 0, eng_ewarn = 0, eng_epass = 0;
  logic        eng_rx_ok = 0, eng_tx_ok = 0, eng_lec_upd = 0;
  logic [2:0]  eng_lec = '0;
  logic        en_err = 0, en_chg = 0;
  logic [15:0] low_code = '0;
  logic        cpu_rd = 0, cpu_wr = 0, cpu_addr = 0;
  logic [7:0]  cpu_wdata = '0;
  logic [15:0] cpu_rdata, irq_id;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_stat_irq dut_i (
    .clk(clk), .rst(rst),
    .eng_boff(eng_boff), .eng_ewarn(eng_ewarn), .eng_epass(eng_epass),
    .eng_rx_ok(eng_rx_ok), .eng_tx_ok(eng_tx_ok),
    .eng_lec_upd(eng_lec_upd), .eng_lec(eng_lec),
    .en_err(en_err), .en_chg(en_chg), .low_code(low_code),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .irq_id(irq_id), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    eng_rx_ok = 0; eng_tx_ok = 0; eng_lec_upd = 0;
    cpu_rd = 0; cpu_wr = 0; cpu_addr = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R11: reset state
    check("R11 irq_id", irq_id, 16'h0000);
    check("R11 irq", {15'd0, irq}, 16'h0000);
    check("R11 rdata", cpu_rdata, 16'h0000);
    rst = 0;
    step();

    for (int i = 0; i < NV; i++) begin
      en_err = VECS[i].ee; en_chg = VECS[i].es;
      eng_boff = VECS[i].bo; eng_ewarn = VECS[i].ew; eng_epass = VECS[i].ep;
      eng_rx_ok = VECS[i].rx; eng_tx_ok = VECS[i].tx;
      eng_lec_upd = VECS[i].lw; eng_lec = VECS[i].lec;
      cpu_rd = VECS[i].rd; cpu_wr = VECS[i].wr; cpu_addr = 0;
      cpu_wdata = VECS[i].wd; low_code = VECS[i].low;
      step();
      check($sformatf("R%0d vec %0d irq_id", VECS[i].req, i), irq_id, VECS[i].expv);
      check($sformatf("R10 vec %0d irq", i), {15'd0, irq}, {15'd0, VECS[i].expv != 0});
    end

    // acknowledge, drop all flags
    quiet();
    eng_boff = 0; eng_ewarn = 0; eng_epass = 0; low_code = 0;
    cpu_rd = 1;
    step();
    quiet();
    check("R7 cleared", irq_id, 16'h0000);

    // R4: write all ones with both enables on, bits 7:5 stay engine-driven
    en_err = 1; en_chg = 1;
    cpu_wr = 1; cpu_wdata = 8'hFF;
    step();
    quiet();
    check("R4 no raise on write", irq_id, 16'h0000);
    cpu_rd = 1;
    step();
    quiet();
    check("R4 status readback", cpu_rdata, 16'h001F);

    // R3/R5: passive flag shows in bit 5, raises nothing
    eng_epass = 1;
    step();
    check("R3 passive no raise", irq_id, 16'h0000);
    cpu_wr = 1; cpu_wdata = 8'h00;
    step();
    quiet();
    cpu_rd = 1;
    step();
    quiet();
    check("R5 read-only flags", cpu_rdata, 16'h0020);
    check("R3 still idle", {15'd0, irq}, 16'h0000);

    // R6: identifier readable without acknowledge
    eng_rx_ok = 1;
    step();
    quiet();
    cpu_rd = 1; cpu_addr = 1;
    step();
    quiet();
    check("R6 id read", cpu_rdata, 16'h8000);
    check("R6 still pending", irq_id, 16'h8000);

    // R11: reset drops a pending interrupt
    eng_epass = 0;
    rst = 1;
    step();
    check("R11 id after reset", irq_id, 16'h0000);
    check("R11 irq after reset", {15'd0, irq}, 16'h0000);
    rst = 0;
    cpu_rd = 1;
    step();
    quiet();
    check("R11 status after reset", cpu_rdata, 16'h0000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule